// File: doc/BRIEF.md
# PCI Target Read Burst Controller

This block is the read-side target engine of a 32-bit PCI interface. It watches the bus for an address phase and latches the address and command. It decodes the address against six base-address windows and claims the transaction with DEVSEL#. It then moves read data from a simple local back-end onto AD[31:0], one word per data phase, until the master ends the burst.

On the local side the back-end sees the latched address, a read/not-write flag and a one-hot window-hit vector. It offers words through a ready/data pair. The controller inserts target wait states, keeping TRDY# deasserted, until the back-end is ready. A registered transfer strobe tells the back-end each time a word has been taken, so that it can advance its address counter. When the master inserts wait states by holding IRDY# high, the word on the bus and TRDY# are held. Even data parity follows each driven word one clock later. At the end of the burst the controller drives DEVSEL# and TRDY# high for one clock and then releases every line it drives.

The bus lines are modelled as separate input, output and output-enable ports. The pad-level tri-state buffers sit outside this block.

Top module: `pci_tgt_rdburst`

## Requirements
- R1: While reset is high, and in the first cycle after it, every output enable (ad_oe, trdy_oe, devsel_oe, par_oe) is low, loc_xfer is low and loc_hit is zero.
- R2: The address phase is the first clock edge with frame_n low while the block is idle. From the next cycle on, loc_addr equals ad_in as sampled at that edge, and loc_rd equals the inverse of bit 0 of the sampled command.
- R3: In the third cycle of a transaction, counting the address cycle as 1, loc_hit holds bit i set exactly when ad[31:24] equals i+1 and the command is a memory read (0110, 1100 or 1110). Otherwise loc_hit is zero and the block drives none of AD, TRDY#, DEVSEL# or PAR for that transaction.
- R4: AD is never driven in the address cycle or in the turnaround cycle (cycle 2). ad_oe is high only while DEVSEL# is driven low.
- R5: A claimed transaction drives DEVSEL# low from cycle 3 with the medium setting (SLOW_DEVSEL=0). With the slow setting it does so from cycle 4, one clock after loc_hit becomes valid.
- R6: TRDY# goes low only in a cycle that follows a clock edge at which loc_rdy was high. In that cycle AD carries loc_data as sampled at that edge. The first TRDY# cannot come before the cycle after DEVSEL# is first asserted.
- R7: loc_xfer is high for exactly one cycle after every edge at which a word was taken, which is the same cycle in which that word first appears on AD. While loc_xfer is high, the back-end must already present the following word.
- R8: When a data phase completes (IRDY# and TRDY# both low at an edge), FRAME# is still low and loc_rdy is high, TRDY# stays low and the next word appears in the next cycle, giving one word per clock.
- R9: While TRDY# is low and IRDY# is high, the next cycle keeps TRDY# low and AD unchanged.
- R10: par_out is driven in the cycle after every cycle in which AD is driven. It equals the XOR of the 32 AD bits and the 4 C/BE# bits of that earlier cycle, so the 37 bits together hold an even number of ones.
- R11: After a data phase completes with FRAME# high, the next cycle drives TRDY# and DEVSEL# high with their enables on and ad_oe low. The cycle after that has all enables low and loc_hit back at zero.
- R12: Every burst transfers each back-end word exactly once and in order. The number of loc_xfer pulses equals the number of completed data phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | FRAME# from the master |
| irdy_n | input | 1 | IRDY# from the master |
| ad_in | input | 32 | AD bus as seen at the pads |
| cbe_in | input | 4 | C/BE# as driven by the master |
| ad_out | output | 32 | Read data to drive on AD |
| ad_oe | output | 1 | Output enable for AD |
| trdy_n | output | 1 | TRDY# value |
| trdy_oe | output | 1 | Output enable for TRDY# |
| devsel_n | output | 1 | DEVSEL# value |
| devsel_oe | output | 1 | Output enable for DEVSEL# |
| par_out | output | 1 | Even parity over AD and C/BE# of the previous cycle |
| par_oe | output | 1 | Output enable for PAR |
| loc_addr | output | 32 | Address latched in the address phase |
| loc_rd | output | 1 | High when the latched command is a read |
| loc_hit | output | 6 | One-hot window-hit vector |
| loc_rdy | input | 1 | Back-end has a word on loc_data |
| loc_data | input | 32 | Word offered by the back-end |
| loc_xfer | output | 1 | One-cycle strobe: a word was taken at the last edge |

## Verification
Results fall due at fixed offsets from the address cycle. The latched address is due in cycle 2. The hit vector and medium DEVSEL# are due in cycle 3, and slow DEVSEL# in cycle 4. The first TRDY# comes one cycle after the first edge with loc_rdy high, and loc_xfer comes in that same cycle. PAR lags the word it covers by one cycle, and the turn-off cycle and the release cycle follow the final data phase by one and two cycles. The bench numbers every cycle of a transaction and samples one nanosecond before the closing edge. It compares each result only in the cycle where it is due. The bench keeps its own expected word sequence for the back-end. Directed runs with the back-end stalled, with both sides always ready, and with random IRDY# and loc_rdy gaps pin down the first-TRDY cycle, the one-word-per-clock rate and the hold behaviour.

// File: rtl/tgtrd_pkg.sv
package tgtrd_pkg;
    localparam int AD_W  = 32;
    localparam int CBE_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for an address phase
        ST_TURN,   // turnaround cycle, decode running
        ST_SLOW,   // extra decode cycle for slow DEVSEL#
        ST_DATA,   // claimed, data phases in progress
        ST_OFF,    // drive TRDY#/DEVSEL# high for one cycle
        ST_SKIP    // not ours, wait for bus idle
    } tgt_state_e;

    typedef struct packed {
        logic [AD_W-1:0]  addr;
        logic [CBE_W-1:0] cmd;
    } addr_phase_t;

    function automatic logic is_mem_read(input logic [CBE_W-1:0] cmd);
        return (cmd == 4'b0110) || (cmd == 4'b1100) || (cmd == 4'b1110);
    endfunction

    function automatic logic even_par(input logic [AD_W-1:0] ad, input logic [CBE_W-1:0] cbe);
        return ^{ad, cbe};
    endfunction
endpackage

// File: rtl/tgtrd_decode.sv
module tgtrd_decode
    import tgtrd_pkg::*;
#(
    parameter int NUM_BAR  = 6,
    parameter int WIN_BITS = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cap,
    input  logic               eval,
    input  logic               clr,
    input  logic [AD_W-1:0]    ad_in,
    input  logic [CBE_W-1:0]   cbe_in,
    output addr_phase_t        ap_q,
    output logic [NUM_BAR-1:0] hit_d,
    output logic [NUM_BAR-1:0] hit_q
);
    localparam int IDX_W = AD_W - WIN_BITS;

    logic rd_cmd;
    assign rd_cmd = is_mem_read(ap_q.cmd);

    for (genvar i = 0; i < NUM_BAR; i++) begin : g_win
        assign hit_d[i] = rd_cmd && (ap_q.addr[AD_W-1:WIN_BITS] == IDX_W'(i + 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ap_q  <= '0;
            hit_q <= '0;
        end else begin
            if (cap) begin
                ap_q.addr <= ad_in;
                ap_q.cmd  <= cbe_in;
            end
            if (clr || cap)
                hit_q <= '0;
            else if (eval)
                hit_q <= hit_d;
        end
    end
endmodule

// File: rtl/tgtrd_dpath.sv
module tgtrd_dpath
    import tgtrd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic [CBE_W-1:0] cbe_in,
    input  logic             loc_rdy,
    input  logic [AD_W-1:0]  loc_data,
    input  logic             ad_oe,
    output logic [AD_W-1:0]  ad_q,
    output logic             trdy_act,
    output logic             xfer_q,
    output logic             done_last,
    output logic             par_q,
    output logic             par_en_q
);
    logic done;
    logic take;

    // A data phase completes when both ready lines are low at the edge.
    assign done      = active && trdy_act && !irdy_n;
    assign done_last = done && frame_n;
    // Load a word into an empty slot, or right behind a completed non-final phase.
    assign take      = active && loc_rdy && (!trdy_act || (done && !frame_n));

    always_ff @(posedge clk) begin
        if (rst) begin
            ad_q     <= '0;
            trdy_act <= 1'b0;
            xfer_q   <= 1'b0;
            par_q    <= 1'b0;
            par_en_q <= 1'b0;
        end else begin
            xfer_q <= take;
            if (take) begin
                ad_q     <= loc_data;
                trdy_act <= 1'b1;
            end else if (done || !active) begin
                trdy_act <= 1'b0;
            end
            par_q    <= even_par(ad_q, cbe_in);
            par_en_q <= ad_oe;
        end
    end
endmodule

// File: rtl/pci_tgt_rdburst.sv
module pci_tgt_rdburst
    import tgtrd_pkg::*;
#(
    parameter int NUM_BAR     = 6,
    parameter int WIN_BITS    = 24,
    parameter bit SLOW_DEVSEL = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_n,
    input  logic               irdy_n,
    input  logic [AD_W-1:0]    ad_in,
    input  logic [CBE_W-1:0]   cbe_in,
    output logic [AD_W-1:0]    ad_out,
    output logic               ad_oe,
    output logic               trdy_n,
    output logic               trdy_oe,
    output logic               devsel_n,
    output logic               devsel_oe,
    output logic               par_out,
    output logic               par_oe,
    output logic [AD_W-1:0]    loc_addr,
    output logic               loc_rd,
    output logic [NUM_BAR-1:0] loc_hit,
    input  logic               loc_rdy,
    input  logic [AD_W-1:0]    loc_data,
    output logic               loc_xfer
);
    tgt_state_e         state_q, state_d;
    addr_phase_t        ap;
    logic [NUM_BAR-1:0] hit_d;
    logic               cap, eval, clr, active, done_last, trdy_act;

    assign cap    = (state_q == ST_IDLE) && !frame_n;
    assign eval   = (state_q == ST_TURN);
    assign clr    = (state_q == ST_OFF);
    assign active = (state_q == ST_DATA);

    tgtrd_decode #(.NUM_BAR(NUM_BAR), .WIN_BITS(WIN_BITS)) u_decode (
        .clk    (clk),
        .rst    (rst),
        .cap    (cap),
        .eval   (eval),
        .clr    (clr),
        .ad_in  (ad_in),
        .cbe_in (cbe_in),
        .ap_q   (ap),
        .hit_d  (hit_d),
        .hit_q  (loc_hit)
    );

    tgtrd_dpath u_dpath (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .frame_n   (frame_n),
        .irdy_n    (irdy_n),
        .cbe_in    (cbe_in),
        .loc_rdy   (loc_rdy),
        .loc_data  (loc_data),
        .ad_oe     (ad_oe),
        .ad_q      (ad_out),
        .trdy_act  (trdy_act),
        .xfer_q    (loc_xfer),
        .done_last (done_last),
        .par_q     (par_out),
        .par_en_q  (par_oe)
    );

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (!frame_n) state_d = ST_TURN;
            ST_TURN: begin
                if (|hit_d) state_d = SLOW_DEVSEL ? ST_SLOW : ST_DATA;
                else        state_d = ST_SKIP;
            end
            ST_SLOW: state_d = ST_DATA;
            ST_DATA: if (done_last) state_d = ST_OFF;
            ST_OFF:  state_d = ST_IDLE;
            ST_SKIP: if (frame_n && irdy_n) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign loc_addr  = ap.addr;
    assign loc_rd    = !ap.cmd[0];
    assign ad_oe     = active;
    assign devsel_oe = active || (state_q == ST_OFF);
    assign devsel_n  = !active;
    assign trdy_oe   = devsel_oe;
    assign trdy_n    = !(active && trdy_act);
endmodule

// File: rtl/pci_tgt_rdburst_chk.sv
module pci_tgt_rdburst_chk
    import tgtrd_pkg::*;
#(
    parameter int NUM_BAR = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               frame_n,
    input logic               irdy_n,
    input logic [CBE_W-1:0]   cbe_in,
    input logic [AD_W-1:0]    ad_out,
    input logic               ad_oe,
    input logic               trdy_n,
    input logic               trdy_oe,
    input logic               devsel_n,
    input logic               devsel_oe,
    input logic               par_out,
    input logic               par_oe,
    input logic [NUM_BAR-1:0] loc_hit,
    input logic               loc_rdy,
    input logic               loc_xfer
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!ad_oe && !trdy_oe && !devsel_oe && !par_oe && !loc_xfer)); // R1
    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(loc_hit)); // R3
    AST_AD_WITH_DEVSEL: assert property (@(posedge clk) disable iff (rst) ad_oe |-> (devsel_oe && !devsel_n)); // R4
    AST_TRDY_AFTER_RDY: assert property (@(posedge clk) disable iff (rst)
        (trdy_oe && !trdy_n && !$past(trdy_oe && !trdy_n)) |-> $past(loc_rdy)); // R6
    AST_XFER_AFTER_RDY: assert property (@(posedge clk) disable iff (rst) loc_xfer |-> $past(loc_rdy)); // R7
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (trdy_oe && !trdy_n && irdy_n) |=> (trdy_oe && !trdy_n && $stable(ad_out))); // R9
    AST_PAR_EVEN: assert property (@(posedge clk) disable iff (rst)
        par_oe |-> (par_out == ^{$past(ad_out), $past(cbe_in)})); // R10
    AST_TURNOFF: assert property (@(posedge clk) disable iff (rst)
        (trdy_oe && !trdy_n && !irdy_n && frame_n) |=> (devsel_oe && devsel_n && trdy_n && !ad_oe)); // R11
    AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (devsel_oe && devsel_n) |=> (!devsel_oe && !trdy_oe)); // R11
endmodule

bind pci_tgt_rdburst pci_tgt_rdburst_chk #(.NUM_BAR(NUM_BAR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .cbe_in    (cbe_in),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .trdy_n    (trdy_n),
    .trdy_oe   (trdy_oe),
    .devsel_n  (devsel_n),
    .devsel_oe (devsel_oe),
    .par_out   (par_out),
    .par_oe    (par_oe),
    .loc_hit   (loc_hit),
    .loc_rdy   (loc_rdy),
    .loc_xfer  (loc_xfer)
);

// File: tb/pci_tgt_rdburst_bench.sv
`timescale 1ns/1ps
module pci_tgt_rdburst_bench;
    localparam int HALF_NS = 10;   // 50 MHz

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_n = 1'b1, irdy_n = 1'b1;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_in = '0;
    logic        loc_rdy = 1'b0;
    logic [31:0] loc_data;
    logic [31:0] ad_out, loc_addr;
    logic        ad_oe, trdy_n, trdy_oe, devsel_n, devsel_oe, par_out, par_oe, loc_rd, loc_xfer;
    logic [5:0]  loc_hit;
    logic [31:0] s_ad_out, s_loc_addr;
    logic        s_ad_oe, s_trdy_n, s_trdy_oe, s_devsel_n, s_devsel_oe, s_par_out, s_par_oe, s_loc_rd, s_loc_xfer;
    logic [5:0]  s_loc_hit;

    always #(HALF_NS) clk = ~clk;

    pci_tgt_rdburst u_pci_tgt_rdburst (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .ad_in(ad_in), .cbe_in(cbe_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .trdy_n(trdy_n), .trdy_oe(trdy_oe), .devsel_n(devsel_n),
        .devsel_oe(devsel_oe), .par_out(par_out), .par_oe(par_oe), .loc_addr(loc_addr), .loc_rd(loc_rd),
        .loc_hit(loc_hit), .loc_rdy(loc_rdy), .loc_data(loc_data), .loc_xfer(loc_xfer));

    pci_tgt_rdburst #(.SLOW_DEVSEL(1'b1)) u_pci_tgt_rdburst_slow (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .ad_in(ad_in), .cbe_in(cbe_in),
        .ad_out(s_ad_out), .ad_oe(s_ad_oe), .trdy_n(s_trdy_n), .trdy_oe(s_trdy_oe), .devsel_n(s_devsel_n),
        .devsel_oe(s_devsel_oe), .par_out(s_par_out), .par_oe(s_par_oe), .loc_addr(s_loc_addr), .loc_rd(s_loc_rd),
        .loc_hit(s_loc_hit), .loc_rdy(loc_rdy), .loc_data(loc_data), .loc_xfer(s_loc_xfer));

    int errors = 0, checks = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mk(input int i);
        return 32'h5A5A_0000 ^ (32'(i) * 32'h9E37_79B1);
    endfunction

    // Back-end model: word stream indexed by a counter that advances on each strobe.
    int be_cnt = 0;
    assign loc_data = mk(be_cnt + (loc_xfer ? 1 : 0));
    always @(posedge clk) if (!rst && loc_xfer) be_cnt <= be_cnt + 1;

    // Transaction bookkeeping shared by master, back-end and monitor.
    int          tcyc = 0, rdy_from = 0, rdy_pct = 100, irdy_pct = 100;
    bit          in_tx = 0, claim = 0, chk_slow = 0, tx_done = 0, completed_last = 0;
    logic [31:0] t_addr;
    logic [3:0]  t_cmd;
    logic [5:0]  exp_hit;
    int          base = 0, words = 0, xfers = 0, n_req = 0, first_trdy = 0, last_cmp = 0, off_cyc = 0;
    logic [31:0] prev_ad;
    logic [3:0]  prev_cbe;
    bit          prev_adoe = 0, prev_wait = 0, prev_trdy_low = 0, prev_cmp = 0;

    always @(negedge clk)
        loc_rdy = in_tx && (tcyc >= rdy_from) && ($urandom_range(0, 99) < rdy_pct);

    // Monitor: samples 1 ns before each rising edge; cycle 1 is the address cycle.
    always begin
        @(negedge clk);
        #(HALF_NS - 1);
        if (!rst) begin
            bit trdy_low, cmp, new_word;
            trdy_low = trdy_oe && !trdy_n;
            cmp      = trdy_low && !irdy_n;
            if (prev_adoe)
                chk(par_oe && (par_out == ^{prev_ad, prev_cbe}), "R10 parity", {par_oe, par_out}, {1'b1, ^{prev_ad, prev_cbe}});
            if (in_tx) begin
                tcyc++;
                if (tcyc <= 2) chk(!ad_oe, "R4 AD idle in address/turnaround", ad_oe, 0);
                if (tcyc == 2) begin
                    chk(loc_addr == t_addr, "R2 latched address", loc_addr, t_addr);
                    chk(loc_rd == !t_cmd[0], "R2 read flag", loc_rd, !t_cmd[0]);
                end
                if (tcyc == 3) begin
                    chk(loc_hit == exp_hit, "R3 hit vector", loc_hit, exp_hit);
                    chk(devsel_oe == claim && devsel_n == !claim, "R5 medium DEVSEL", {devsel_oe, devsel_n}, {claim, !claim});
                    if (claim) chk(ad_oe, "R4 AD driven with DEVSEL", ad_oe, 1);
                    if (chk_slow) chk(!s_devsel_oe, "R5 slow DEVSEL not yet", s_devsel_oe, 0);
                end
                if (tcyc == 4 && chk_slow) chk(s_devsel_oe && !s_devsel_n, "R5 slow DEVSEL", {s_devsel_oe, s_devsel_n}, 2'b10);
                if (!claim) begin
                    chk(!devsel_oe && !trdy_oe && !ad_oe && !par_oe, "R3 unclaimed stays off", {devsel_oe, trdy_oe, ad_oe, par_oe}, 0);
                end else if (off_cyc == 0) begin
                    if (prev_wait) chk(trdy_low && ad_out == prev_ad, "R9 hold during master wait", {trdy_low, ad_out}, {1'b1, prev_ad});
                    new_word = trdy_low && (!prev_trdy_low || prev_cmp);
                    if (tcyc >= 3) chk(loc_xfer == new_word, "R7 strobe with new word", loc_xfer, new_word);
                    if (loc_xfer) xfers++;
                    if (trdy_low && first_trdy == 0) first_trdy = tcyc;
                    if (cmp) begin
                        chk(ad_out == mk(base + words), "R12 word order", ad_out, mk(base + words));
                        words++;
                        last_cmp = tcyc;
                        if (frame_n) off_cyc = tcyc + 1;
                    end
                end else if (tcyc == off_cyc) begin
                    chk(trdy_oe && trdy_n && devsel_oe && devsel_n && !ad_oe && par_oe, "R11 turn-off cycle",
                        {trdy_oe, trdy_n, devsel_oe, devsel_n, ad_oe, par_oe}, 6'b111101);
                    chk(xfers == words && words == n_req, "R12 exactly once", {xfers[15:0], words[15:0]}, {n_req[15:0], n_req[15:0]});
                end else if (tcyc == off_cyc + 1) begin
                    chk(!trdy_oe && !devsel_oe && !ad_oe && !par_oe && loc_hit == 0, "R11 release",
                        {trdy_oe, devsel_oe, ad_oe, par_oe, loc_hit}, 0);
                    tx_done = 1;
                    in_tx   = 0;
                end
            end
            prev_ad = ad_out; prev_cbe = cbe_in; prev_adoe = ad_oe;
            prev_wait = trdy_low && irdy_n; prev_trdy_low = trdy_low; prev_cmp = cmp;
            completed_last = cmp;
        end
    end

    // Master model: one address phase, then n data phases with optional IRDY# wait states.
    task automatic run_tx(input logic [31:0] a, input logic [3:0] c, input int n);
        int rem;
        @(negedge clk);
        t_addr = a; t_cmd = c; n_req = n;
        exp_hit = (is_rd(c) && a[31:24] >= 1 && a[31:24] <= 6) ? 6'(1 << (a[31:24] - 1)) : 6'd0;
        claim = (exp_hit != 0);
        base = be_cnt; words = 0; xfers = 0; first_trdy = 0; last_cmp = 0; off_cyc = 0;
        tcyc = 0; tx_done = 0; completed_last = 0; prev_wait = 0; prev_trdy_low = 0; prev_cmp = 0;
        in_tx = 1;
        frame_n = 0; irdy_n = 1; ad_in = a; cbe_in = c;
        @(negedge clk);
        ad_in = '0; cbe_in = 4'($urandom_range(0, 15));
        if (!claim) begin
            frame_n = 1; irdy_n = 0;
            repeat (4) @(negedge clk);
            irdy_n = 1;
            @(negedge clk);
            in_tx = 0;
            return;
        end
        rem = n;
        forever begin
            bit fresh;
            fresh = completed_last;
            if (fresh) begin
                rem--;
                if (rem == 0) begin frame_n = 1; irdy_n = 1; break; end
                cbe_in = 4'($urandom_range(0, 15));
            end
            if (irdy_n || fresh) begin
                if ($urandom_range(0, 99) < irdy_pct) begin
                    irdy_n = 0;
                    if (rem == 1) frame_n = 1;
                end else irdy_n = 1;
            end
            @(negedge clk);
        end
        while (!tx_done) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic bit is_rd(input logic [3:0] c);
        return c == 4'b0110 || c == 4'b1100 || c == 4'b1110;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    int gcyc = 0;
    always @(posedge clk) begin
        gcyc++;
        if (gcyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected<=150000 cycles", gcyc);
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state, sampled during reset and just after release
        chk(!ad_oe && !trdy_oe && !devsel_oe && !par_oe && !loc_xfer && loc_hit == 0, "R1 in reset",
            {ad_oe, trdy_oe, devsel_oe, par_oe, loc_xfer, loc_hit}, 0);
        rst = 0;
        @(negedge clk); #(HALF_NS - 1);
        chk(!ad_oe && !trdy_oe && !devsel_oe && !par_oe && !loc_xfer && loc_hit == 0, "R1 after reset",
            {ad_oe, trdy_oe, devsel_oe, par_oe, loc_xfer, loc_hit}, 0);

        // R8/R5: both sides always ready, slow instance watched for DEVSEL# timing
        chk_slow = 1; rdy_pct = 100; irdy_pct = 100; rdy_from = 0;
        run_tx(32'h0100_0040, 4'b0110, 4);
        chk_slow = 0;
        chk(first_trdy == 4, "R6 first TRDY cycle", first_trdy, 4);
        chk(last_cmp - first_trdy == 3, "R8 one word per clock", last_cmp - first_trdy, 3);

        // single-word read-multiple to window 5
        run_tx(32'h0600_0000, 4'b1100, 1);
        chk(words == 1, "R12 single word", words, 1);

        // R6: back-end stalls until cycle 8, so TRDY# first in cycle 9
        rdy_from = 7;
        run_tx(32'h0300_1000, 4'b1110, 2);
        chk(first_trdy == 9, "R6 target wait states", first_trdy, 9);
        rdy_from = 0;

        // R3: outside every window, and a write to a valid window
        run_tx(32'h0700_0000, 4'b0110, 1);
        run_tx(32'h0200_0000, 4'b0111, 1);

        // random wait states on both sides
        irdy_pct = 60; rdy_pct = 50;
        for (int k = 0; k < 25; k++)
            run_tx({8'($urandom_range(1, 6)), 24'($urandom)}, 4'b0110, $urandom_range(1, 8));

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule